// File: doc/BRIEF.md
# Table-Driven Event Address Remapper

This block sits between an inbound event queue and up to four receiver links. It pops one 16-bit event address at a time and turns it into zero, one or several outgoing events. A 2-bit mode selects the behaviour. In forwarding mode the address goes out unchanged. In single-lookup mode the address selects a word in an external table memory, and that word becomes the outgoing address. In fan-out mode the address selects a 24-bit pointer entry. That entry either names a list of target addresses to walk, or carries one address to emit directly.

Each outgoing event runs a full four-phase request/acknowledge exchange on one receiver channel. A steering setting divides the 16-bit output address across one, two or four receivers. The table memory is a synchronous-read RAM with one cycle of read latency, driven by this block. A host may only write the memory while the block reports that it is idle. The idle flag rises once the enable is low and any event already accepted, including a whole target list, has finished.

Top module: `addr_remap_engine`

## Requirements
- R1: After reset no request is raised and no memory read is made. `idle` is 1 while `enable` is 0, and `in_ready` is 1 (with `idle` 0) as soon as `enable` is 1.
- R2: Mode code 01 (forwarding) emits exactly one event whose address is the input address, with no memory read.
- R3: Mode code 00 pops the input event and emits nothing.
- R4: Mode code 10 (single lookup) reads the word at memory index equal to the input address and emits one event carrying bits 15:0 of that word.
- R5: Mode code 11 with pointer bits 23:22 = 00 reads memory sequentially from the 21-bit start address in bits 20:0. It emits one event per word, in list order, and stops at the word 0xFFFF, which is never emitted. A list that starts with 0xFFFF emits nothing.
- R6: Mode code 11 with pointer bits 23:22 = 11 emits one event carrying bits 15:0 of the pointer word and makes no list read.
- R7: Mode code 11 with pointer bits 23:22 = 01 or 10 pops the input event and emits nothing.
- R8: Steering code 00 uses channel 0 with the full 16-bit address. Code 01 selects channel by bit 15 and emits bits 14:0 zero-extended. Code 10 selects channel by bits 15:14 and emits bits 13:0 zero-extended. Code 11 behaves as code 00. At most one request line is high at a time.
- R9: A request stays high with a stable address until its acknowledge rises, and drops only after that. No memory read and no new request starts until the acknowledge has fallen again.
- R10: `enable`, mode and steering are sampled only when an event is accepted. Lowering `enable` in the middle of a list lets the list finish, and `idle` stays 0 until then.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Allows new events to be accepted |
| mode | input | 2 | Remapping mode code |
| chan_cfg | input | 2 | Receiver steering code |
| in_valid | input | 1 | Inbound event present |
| in_addr | input | 16 | Inbound event address |
| in_ready | output | 1 | Inbound event is popped when high with in_valid |
| mem_rd | output | 1 | Table memory read strobe |
| mem_addr | output | 21 | Table memory word index |
| mem_rdata | input | 24 | Table memory data, valid one cycle after the strobe |
| out_req | output | 4 | Per-receiver request lines |
| out_ack | input | 4 | Per-receiver acknowledge lines |
| out_addr | output | 16 | Outgoing event address |
| idle | output | 1 | Disabled and at rest; table memory is free for the host |

## Verification
On every cycle the embedded assertions check the handshake discipline: one request at most, a request held stable until acknowledged and dropped only after acknowledge, and steering that keeps to the allowed channels. They also check that configuration captured at acceptance stays fixed during a transaction, and that an idle block neither reads memory nor requests. The bench scenarios are the only way to show the content of the results. They cover address values after the table walk, the number and order of list events, the terminator being withheld, the absence of list reads on direct entries, and a scan that completes after `enable` has dropped.

// File: rtl/remap_pkg.sv
package remap_pkg;

    localparam int EV_W  = 16;
    localparam int PTR_W = 21;
    localparam int WORD_W = 24;

    typedef enum logic [1:0] {
        MODE_OFF  = 2'b00,
        MODE_PASS = 2'b01,
        MODE_ONE  = 2'b10,
        MODE_MANY = 2'b11
    } map_mode_e;

    typedef enum logic [1:0] {
        STEER_ONE  = 2'b00,
        STEER_TWO  = 2'b01,
        STEER_FOUR = 2'b10,
        STEER_RSV  = 2'b11
    } steer_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PTR_RD,
        ST_PTR_WAIT,
        ST_LIST_RD,
        ST_LIST_WAIT,
        ST_EMIT,
        ST_RELEASE
    } eng_state_e;

    localparam logic [1:0] ENTRY_LIST   = 2'b00;
    localparam logic [1:0] ENTRY_DIRECT = 2'b11;

    typedef struct packed {
        logic [1:0]      ch;
        logic [EV_W-1:0] addr;
    } steer_t;

    function automatic steer_t steer_event(steer_e cfg, logic [EV_W-1:0] a);
        steer_t s;
        s.ch   = 2'd0;
        s.addr = a;
        case (cfg)
            STEER_TWO: begin
                s.ch   = {1'b0, a[EV_W-1]};
                s.addr = {1'b0, a[EV_W-2:0]};
            end
            STEER_FOUR: begin
                s.ch   = a[EV_W-1 -: 2];
                s.addr = {2'b00, a[EV_W-3:0]};
            end
            default: ;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/remap_ctrl.sv
module remap_ctrl
    import remap_pkg::*;
#(
    parameter int AW  = EV_W,
    parameter int MAW = PTR_W,
    parameter int MDW = WORD_W
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           enable,
    input  map_mode_e      mode,
    input  steer_e         cfg,
    input  logic           in_valid,
    input  logic [AW-1:0]  in_addr,
    output logic           in_ready,
    output logic           mem_rd,
    output logic [MAW-1:0] mem_addr,
    input  logic [MDW-1:0] mem_rdata,
    output logic           req_phase,
    output logic [AW-1:0]  ev_addr,
    output steer_e         cfg_q,
    input  logic           ack_sel,
    output logic           idle
);

    localparam logic [AW-1:0] TERM = {AW{1'b1}};

    eng_state_e     state;
    map_mode_e      mode_q;
    logic [AW-1:0]  addr_q;
    logic [MAW-1:0] ptr_q;
    logic           more_q;
    logic [1:0]     entry_code;

    assign entry_code = mem_rdata[MDW-1 -: 2];

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            mode_q <= MODE_OFF;
            cfg_q  <= STEER_ONE;
            addr_q <= '0;
            ptr_q  <= '0;
            more_q <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (enable && in_valid) begin
                        mode_q <= mode;
                        cfg_q  <= cfg;
                        addr_q <= in_addr;
                        ptr_q  <= MAW'(in_addr);
                        more_q <= 1'b0;
                        case (mode)
                            MODE_PASS: state <= ST_EMIT;
                            MODE_ONE, MODE_MANY: state <= ST_PTR_RD;
                            default: state <= ST_IDLE;
                        endcase
                    end
                end
                ST_PTR_RD: state <= ST_PTR_WAIT;
                ST_PTR_WAIT: begin
                    if (mode_q == MODE_ONE) begin
                        addr_q <= mem_rdata[AW-1:0];
                        state  <= ST_EMIT;
                    end else if (entry_code == ENTRY_LIST) begin
                        ptr_q <= mem_rdata[MAW-1:0];
                        state <= ST_LIST_RD;
                    end else if (entry_code == ENTRY_DIRECT) begin
                        addr_q <= mem_rdata[AW-1:0];
                        state  <= ST_EMIT;
                    end else begin
                        state <= ST_IDLE;
                    end
                end
                ST_LIST_RD: state <= ST_LIST_WAIT;
                ST_LIST_WAIT: begin
                    if (mem_rdata[AW-1:0] == TERM) begin
                        state <= ST_IDLE;
                    end else begin
                        addr_q <= mem_rdata[AW-1:0];
                        ptr_q  <= ptr_q + 1'b1;
                        more_q <= 1'b1;
                        state  <= ST_EMIT;
                    end
                end
                ST_EMIT: if (ack_sel) state <= ST_RELEASE;
                ST_RELEASE: if (!ack_sel) state <= more_q ? ST_LIST_RD : ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign in_ready  = (state == ST_IDLE) && enable;
    assign idle      = (state == ST_IDLE) && !enable;
    assign mem_rd    = (state == ST_PTR_RD) || (state == ST_LIST_RD);
    assign mem_addr  = ptr_q;
    assign req_phase = (state == ST_EMIT);
    assign ev_addr   = addr_q;

    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        idle |-> (!mem_rd && !req_phase));

    assert_cfg_held_R10: assert property (@(posedge clk) disable iff (rst)
        (state != ST_IDLE) |=> ($stable(mode_q) && $stable(cfg_q)));

    assert_no_read_in_handshake_R9: assert property (@(posedge clk) disable iff (rst)
        (req_phase || state == ST_RELEASE) |-> !mem_rd);

    assert_accept_no_read_R1: assert property (@(posedge clk) disable iff (rst)
        in_ready |-> !mem_rd);

endmodule

// File: rtl/remap_out_port.sv
module remap_out_port
    import remap_pkg::*;
#(
    parameter int AW  = EV_W,
    parameter int NCH = 4
) (
    input  logic           clk,
    input  logic           rst,
    input  steer_e         cfg,
    input  logic [AW-1:0]  ev_addr,
    input  logic           req_phase,
    input  logic [NCH-1:0] out_ack,
    output logic [NCH-1:0] out_req,
    output logic [AW-1:0]  out_addr,
    output logic           ack_sel
);

    localparam int CW = $clog2(NCH);

    steer_t s;
    assign s        = steer_event(cfg, ev_addr);
    assign out_addr = s.addr;
    assign ack_sel  = out_ack[s.ch[CW-1:0]];

    for (genvar g = 0; g < NCH; g++) begin : g_req
        assign out_req[g] = req_phase && (s.ch[CW-1:0] == CW'(g));
    end

    assert_req_onehot_R8: assert property (@(posedge clk) disable iff (rst)
        $onehot0(out_req));

    assert_two_rx_range_R8: assert property (@(posedge clk) disable iff (rst)
        (cfg == STEER_TWO) |-> (out_req[NCH-1:2] == '0));

    assert_req_hold_R9: assert property (@(posedge clk) disable iff (rst)
        ((|out_req) && !ack_sel) |=> ($stable(out_req) && $stable(out_addr)));

    assert_req_drop_after_ack_R9: assert property (@(posedge clk) disable iff (rst)
        $fell(|out_req) |-> $past(ack_sel));

endmodule

// File: rtl/addr_remap_engine.sv
module addr_remap_engine
    import remap_pkg::*;
#(
    parameter int AW  = EV_W,
    parameter int MAW = PTR_W,
    parameter int MDW = WORD_W,
    parameter int NCH = 4
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           enable,
    input  logic [1:0]     mode,
    input  logic [1:0]     chan_cfg,
    input  logic           in_valid,
    input  logic [AW-1:0]  in_addr,
    output logic           in_ready,
    output logic           mem_rd,
    output logic [MAW-1:0] mem_addr,
    input  logic [MDW-1:0] mem_rdata,
    output logic [NCH-1:0] out_req,
    input  logic [NCH-1:0] out_ack,
    output logic [AW-1:0]  out_addr,
    output logic           idle
);

    logic          req_phase;
    logic          ack_sel;
    logic [AW-1:0] ev_addr;
    steer_e        cfg_q;

    remap_ctrl #(.AW(AW), .MAW(MAW), .MDW(MDW)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .enable    (enable),
        .mode      (map_mode_e'(mode)),
        .cfg       (steer_e'(chan_cfg)),
        .in_valid  (in_valid),
        .in_addr   (in_addr),
        .in_ready  (in_ready),
        .mem_rd    (mem_rd),
        .mem_addr  (mem_addr),
        .mem_rdata (mem_rdata),
        .req_phase (req_phase),
        .ev_addr   (ev_addr),
        .cfg_q     (cfg_q),
        .ack_sel   (ack_sel),
        .idle      (idle)
    );

    remap_out_port #(.AW(AW), .NCH(NCH)) u_port (
        .clk       (clk),
        .rst       (rst),
        .cfg       (cfg_q),
        .ev_addr   (ev_addr),
        .req_phase (req_phase),
        .out_ack   (out_ack),
        .out_req   (out_req),
        .out_addr  (out_addr),
        .ack_sel   (ack_sel)
    );

endmodule

// File: tb/addr_remap_engine_tb.sv
module addr_remap_engine_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        enable = 1'b0;
    logic [1:0]  mode = 2'b00;
    logic [1:0]  chan_cfg = 2'b00;
    logic        in_valid = 1'b0;
    logic [15:0] in_addr = '0;
    logic        in_ready;
    logic        mem_rd;
    logic [20:0] mem_addr;
    logic [23:0] mem_rdata = '0;
    logic [3:0]  out_req;
    logic [3:0]  out_ack = '0;
    logic [15:0] out_addr;
    logic        idle;

    always #2 clk = ~clk;

    addr_remap_engine u_dut (
        .clk(clk), .rst(rst), .enable(enable), .mode(mode), .chan_cfg(chan_cfg),
        .in_valid(in_valid), .in_addr(in_addr), .in_ready(in_ready),
        .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
        .out_req(out_req), .out_ack(out_ack), .out_addr(out_addr), .idle(idle)
    );

    int checks = 0;
    int errors = 0;

    // table memory model
    function automatic logic [23:0] mem_word(logic [20:0] a);
        if (a < 21'h10000) begin
            case (a[15:0])
                16'h0010: return {2'b00, 1'b0, 21'h010000};
                16'h0020: return {2'b11, 6'h00, 16'h8022};
                16'h0030: return {2'b01, 6'h00, 16'h1234};
                16'h0040: return {2'b10, 6'h00, 16'h1234};
                16'h0050: return {2'b00, 1'b0, 21'h010100};
                default:  return {2'b01, 6'h00, a[15:0] ^ 16'h5A5A};
            endcase
        end
        case (a)
            21'h010000: return 24'h001234;
            21'h010001: return 24'h00C005;
            21'h010002: return 24'h008ABC;
            default:    return 24'h00FFFF;
        endcase
    endfunction

    always @(posedge clk) if (mem_rd) mem_rdata <= mem_word(mem_addr);

    // receiver model: acknowledge two cycles after request, release after drop
    int ack_dly = 0;
    always @(negedge clk) begin
        if (out_req != 0 && out_ack == 0) begin
            ack_dly <= ack_dly + 1;
            if (ack_dly >= 2) begin out_ack <= out_req; ack_dly <= 0; end
        end else if (out_req == 0 && out_ack != 0) begin
            out_ack <= '0;
        end
    end

    // event monitor
    logic [3:0]  prev_req = '0;
    int          ev_n = 0;
    int          ev_ch [8];
    logic [15:0] ev_ad [8];
    int          list_reads = 0;
    int          proto_err = 0;
    always @(negedge clk) begin
        if (out_req != 0 && prev_req == 0 && ev_n < 8) begin
            for (int i = 0; i < 4; i++) if (out_req[i]) ev_ch[ev_n] = i;
            ev_ad[ev_n] = out_addr;
            ev_n++;
        end
        if (prev_req != 0 && out_req != prev_req && (prev_req & out_ack) == 0) proto_err++;
        if (mem_rd && (out_req != 0 || out_ack != 0)) proto_err++;
        if (mem_rd && mem_addr >= 21'h10000) list_reads++;
        prev_req = out_req;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic run(input logic [1:0] m, input logic [1:0] c, input logic [15:0] a);
        ev_n = 0; list_reads = 0;
        @(negedge clk);
        mode = m; chan_cfg = c; in_addr = a; in_valid = 1'b1; enable = 1'b1;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0; enable = 1'b0;
        for (int t = 0; t < 300 && !idle; t++) @(negedge clk);
    endtask

    // {mode, steer, in_addr, n_events, channel, out_addr}
    localparam logic [39:0] VECS [12] = '{
        {2'b01, 2'b00, 16'hBEEF, 2'd1, 2'd0, 16'hBEEF},  // R2
        {2'b01, 2'b01, 16'hBEEF, 2'd1, 2'd1, 16'h3EEF},  // R8
        {2'b01, 2'b10, 16'hBEEF, 2'd1, 2'd2, 16'h3EEF},  // R8
        {2'b01, 2'b10, 16'h4001, 2'd1, 2'd1, 16'h0001},  // R8
        {2'b00, 2'b00, 16'h1111, 2'd0, 2'd0, 16'h0000},  // R3
        {2'b10, 2'b00, 16'h0123, 2'd1, 2'd0, 16'h5B79},  // R4
        {2'b10, 2'b01, 16'h0020, 2'd1, 2'd1, 16'h0022},  // R4
        {2'b11, 2'b00, 16'h0020, 2'd1, 2'd0, 16'h8022},  // R6
        {2'b11, 2'b00, 16'h0030, 2'd0, 2'd0, 16'h0000},  // R7
        {2'b11, 2'b00, 16'h0040, 2'd0, 2'd0, 16'h0000},  // R7
        {2'b11, 2'b00, 16'h0050, 2'd0, 2'd0, 16'h0000},  // R5 empty list
        {2'b11, 2'b11, 16'hBEEF, 2'd0, 2'd0, 16'h0000}   // R7
    };

    // watchdog
    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 50000) begin
            checks++; errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 50000);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(idle == 1'b1, "R1 idle", idle, 1);
        chk(out_req == 4'b0, "R1 out_req", out_req, 0);
        chk(mem_rd == 1'b0, "R1 mem_rd", mem_rd, 0);
        enable = 1'b1;
        #0;
        @(negedge clk);
        chk(in_ready == 1'b1 && idle == 1'b0, "R1 ready", {in_ready, idle}, 2'b10);
        enable = 1'b0;

        for (int v = 0; v < 12; v++) begin
            run(VECS[v][39:38], VECS[v][37:36], VECS[v][35:20]);
            chk(ev_n == int'(VECS[v][19:18]), "R2/R3/R4/R6/R7/R8 count", ev_n, VECS[v][19:18]);
            if (VECS[v][19:18] == 2'd1) begin
                chk(ev_ch[0] == int'(VECS[v][17:16]), "R8 channel", ev_ch[0], VECS[v][17:16]);
                chk(ev_ad[0] == VECS[v][15:0], "R2/R4/R6 address", ev_ad[0], VECS[v][15:0]);
            end
            if (v == 7) chk(list_reads == 0, "R6 no list read", list_reads, 0);
        end

        // R5 / R10: list walk with enable dropped mid-scan, four receivers
        ev_n = 0; list_reads = 0;
        @(negedge clk);
        mode = 2'b11; chan_cfg = 2'b10; in_addr = 16'h0010; in_valid = 1'b1; enable = 1'b1;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0; enable = 1'b0;
        for (int t = 0; t < 100 && out_req == 0; t++) @(negedge clk);
        chk(idle == 1'b0, "R10 busy mid-scan", idle, 0);
        for (int t = 0; t < 300 && !idle; t++) @(negedge clk);
        chk(ev_n == 3, "R5 list length", ev_n, 3);
        chk(ev_ch[0] == 0 && ev_ad[0] == 16'h1234, "R5 first", {ev_ch[0][1:0], ev_ad[0]}, 18'h01234);
        chk(ev_ch[1] == 3 && ev_ad[1] == 16'h0005, "R5 second", {ev_ch[1][1:0], ev_ad[1]}, 18'h30005);
        chk(ev_ch[2] == 2 && ev_ad[2] == 16'h0ABC, "R5 third", {ev_ch[2][1:0], ev_ad[2]}, 18'h20ABC);
        chk(list_reads == 4, "R5 reads up to terminator", list_reads, 4);

        // R10: mode change while busy does not alter the running event
        ev_n = 0;
        @(negedge clk);
        mode = 2'b10; chan_cfg = 2'b00; in_addr = 16'h0123; in_valid = 1'b1; enable = 1'b1;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0; enable = 1'b0; mode = 2'b01; chan_cfg = 2'b10;
        for (int t = 0; t < 300 && !idle; t++) @(negedge clk);
        chk(ev_n == 1 && ev_ad[0] == 16'h5B79 && ev_ch[0] == 0, "R10 config latched",
            ev_ad[0], 16'h5B79);

        // R9 handshake discipline seen over all traffic
        chk(proto_err == 0, "R9 handshake", proto_err, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule